// File: doc/BRIEF.md
# Watchdog Timer with Selectable Overflow Action

The block is a watchdog counter that advances on one of several slow tick strobes. Software picks the strobe through a 3-bit rate field and starts counting with an enable bit. It keeps the watchdog quiet by writing a kick bit, which returns the counter to zero. If the count reaches its limit, the block takes one of two actions. In interrupt mode it sets a pending flag that drives the interrupt line until software writes 1 to clear it. In reset mode it raises a one-cycle reset-request pulse for the system reset logic.

All control goes through one register with a write strobe and a combinational read port. The kick bit reads back as 1 from the write until the counter has actually been zeroed, one clock later. A tick that causes an overflow also restarts the counter from zero, so a watchdog that is never kicked overflows again every `LIMIT` ticks. With the default `LIMIT` of 176, rate code 0 with a 1 kHz strobe gives a 176 ms timeout. Higher codes are meant for slower strobes.

Top module: `wdog_sentinel`

## Requirements
- R1: After reset the read word is 0, `irq` is 0 and `rst_req` is 0.
- R2: The enable (bit 4), action select (bit 5) and rate field (bits 3..1) read back as last written, and bits 31..7 always read 0.
- R3: While enabled, overflow happens on exactly the `LIMIT`-th pulse of `tick_en[rate]`, counted from zero. Pulses on every other `tick_en` line have no effect on the count.
- R4: In interrupt mode (bit 5 = 0), an overflow sets the pending bit (bit 6) and raises `irq` in the cycle after the overflowing tick. Both stay set until a write with bit 6 = 1, and a write with bit 6 = 0 leaves them unchanged.
- R5: In reset mode (bit 5 = 1), an overflow makes `rst_req` high for exactly one cycle, starting in the cycle after the overflowing tick, and leaves the pending bit at 0.
- R6: Writing 1 to bit 0 makes bit 0 read 1 for one cycle and then 0, and the counter is back at zero at that point. The next overflow then needs a full `LIMIT` pulses.
- R7: After an overflow with the enable still set, the counter restarts from zero, and the next overflow comes after another `LIMIT` pulses.
- R8: While the enable is 0, tick pulses are ignored and the count is held. After re-enabling, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 7 | Write data, bits 6..0 of the control register |
| reg_rdata | output | 32 | Control register read value |
| tick_en | input | 2**SEL_W | One tick strobe per rate code |
| irq | output | 1 | Interrupt, follows the pending bit |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A register write takes effect at the clock edge where the strobe is sampled, so the bench reads fields back at the next falling edge. The kick bit reads 1 at that falling edge and 0 one falling edge later. An overflow, whether the pending bit or the reset pulse, is caused by the tick sampled at an edge and is visible at the falling edge that follows. The bench therefore checks for no event after `LIMIT`-1 pulses and for the event right after the `LIMIT`-th pulse. It checks `rst_req` once more one cycle later to confirm the pulse is a single cycle. The bench sweeps every rate code in both modes, and it drives all inputs on falling edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BIT_KICK  = 0;
  localparam int BIT_RATE  = 1;
  localparam int BIT_EN    = 4;
  localparam int BIT_MODE  = 5;
  localparam int BIT_PEND  = 6;
  localparam int CTL_W     = 7;
  localparam int RD_W      = 32;

  // next counter value after an accepted tick: wraps at limit
  function automatic int next_count(input int cur, input int limit);
    return (cur + 1 >= limit) ? 0 : cur + 1;
  endfunction

  function automatic logic hits_limit(input int cur, input int limit);
    return (cur + 1 >= limit);
  endfunction
endpackage

// File: rtl/wdog_tick_pick.sv
module wdog_tick_pick #(
  parameter int SEL_W = 3,
  localparam int NTICK = 1 << SEL_W
) (
  input  logic [NTICK-1:0] tick_en,
  input  logic [SEL_W-1:0] rate,
  output logic             tick
);
  logic [NTICK-1:0] hit;
  for (genvar g = 0; g < NTICK; g++) begin : g_pick
    assign hit[g] = tick_en[g] && (rate == SEL_W'(g));
  end
  assign tick = |hit;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int LIMIT = 176,
  localparam int CNT_W = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic kick,
  output logic ovf
);
  import wdog_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = enable && tick && !kick;
  assign ovf  = step && hits_limit(int'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (kick)  cnt_q <= '0;
    else if (step)  cnt_q <= CNT_W'(next_count(int'(cnt_q), LIMIT));
  end

  // R7: overflow restarts the count
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == '0));
  // R8: disabled counter holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !kick) |=> $stable(cnt_q));
  // R6: kick zeroes the counter
  a_r6_kick_zero: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
  parameter int SEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [wdog_pkg::CTL_W-1:0] wdata,
  input  logic                      ovf,
  output logic                      enable,
  output logic                      mode_rst,
  output logic [SEL_W-1:0]          rate,
  output logic                      kick,
  output logic                      pend,
  output logic                      rst_pulse
);
  import wdog_pkg::*;

  logic pend_clr_wr;
  logic kick_wr;

  assign pend_clr_wr = wr && wdata[BIT_PEND];
  assign kick_wr     = wr && wdata[BIT_KICK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      mode_rst <= 1'b0;
      rate     <= '0;
    end else if (wr) begin
      enable   <= wdata[BIT_EN];
      mode_rst <= wdata[BIT_MODE];
      rate     <= wdata[BIT_RATE +: SEL_W];
    end
  end

  // kick stays visible until the counter has been zeroed (one edge)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kick <= 1'b0;
    else if (kick_wr) kick <= 1'b1;
    else              kick <= 1'b0;
  end

  // a new overflow wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (ovf && !mode_rst)   pend <= 1'b1;
    else if (pend_clr_wr)        pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse <= 1'b0;
    else        rst_pulse <= ovf && mode_rst;
  end

  // R4: interrupt-mode overflow sets pending
  a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !mode_rst) |=> pend);
  // R4: pending only drops on a write of 1 to its bit
  a_r4_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr_wr) |=> pend);
  // R5: reset-mode overflow gives a pulse
  a_r5_rst_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && mode_rst) |=> rst_pulse);
  // R5: pulse is one cycle wide
  a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  // R6: kick bit clears itself
  a_r6_kick_self: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !kick_wr) |=> !kick);
endmodule

// File: rtl/wdog_sentinel.sv
module wdog_sentinel #(
  parameter int SEL_W = 3,
  parameter int LIMIT = 176,
  localparam int NTICK = 1 << SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [wdog_pkg::CTL_W-1:0]  reg_wdata,
  output logic [wdog_pkg::RD_W-1:0]   reg_rdata,
  input  logic [NTICK-1:0]            tick_en,
  output logic                        irq,
  output logic                        rst_req
);
  import wdog_pkg::*;

  logic             enable, mode_rst, kick, pend, tick, ovf;
  logic [SEL_W-1:0] rate;

  wdog_ctl #(.SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .ovf(ovf),
    .enable(enable), .mode_rst(mode_rst), .rate(rate), .kick(kick),
    .pend(pend), .rst_pulse(rst_req)
  );

  wdog_tick_pick #(.SEL_W(SEL_W)) u_pick (
    .tick_en(tick_en), .rate(rate), .tick(tick)
  );

  wdog_count #(.LIMIT(LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .kick(kick),
    .ovf(ovf)
  );

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[BIT_KICK]           = kick;
    reg_rdata[BIT_RATE +: SEL_W]  = rate;
    reg_rdata[BIT_EN]             = enable;
    reg_rdata[BIT_MODE]           = mode_rst;
    reg_rdata[BIT_PEND]           = pend;
  end

  assign irq = pend;

  initial begin
    a_r3_params: assert (LIMIT >= 2 && SEL_W == 3);
  end

  // R3: no overflow without enable
  a_r3_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rst_req);
  // R2: reserved bits read zero
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[RD_W-1:CTL_W] == '0);
endmodule

// File: tb/test_wdog_sentinel.sv
module test_wdog_sentinel;
  localparam int LIM = 6;
  localparam int NT  = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [6:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NT-1:0] tick_en = '0;
  logic        irq, rst_req;
  int n_chk = 0, n_bad = 0, cyc = 0;

  wdog_sentinel #(.SEL_W(3), .LIMIT(LIM)) i_wdog_sentinel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_en(tick_en), .irq(irq), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ctl(input logic pc, input logic md,
                                     input logic en, input int rt, input logic kk);
    return {pc, md, en, 3'(rt), kk};
  endfunction

  task automatic wr(input logic [6:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic tk(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = NT'(1) << idx;
      @(negedge clk); tick_en = '0;
    end
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reg_rdata == 0 && !irq && !rst_req, "R1 reset", int'(reg_rdata), 0);
    rst_n = 1;
    @(negedge clk);

    for (int md = 0; md < 2; md++) begin
      for (int rt = 0; rt < NT; rt++) begin
        wr(ctl(1'b1, md[0], 1'b1, rt, 1'b1));
        check(reg_rdata[0] == 1'b1, "R6 kick reads 1", int'(reg_rdata[0]), 1);
        @(negedge clk);
        check(reg_rdata[0] == 1'b0, "R6 kick self-clear", int'(reg_rdata[0]), 0);
        check(reg_rdata == {25'b0, 1'b0, md[0], 1'b1, 3'(rt), 1'b0},
              "R2 readback", int'(reg_rdata), int'({md[0], 1'b1, 3'(rt), 1'b0}));
        // other rates ignored (R3)
        for (int o = 0; o < NT; o++) if (o != rt) tk(o, LIM);
        tk(rt, LIM - 1);
        check(!irq && !rst_req && !reg_rdata[6], "R3 no early overflow",
              int'(irq) + int'(rst_req), 0);
        tk(rt, 1);
        if (md == 0) begin
          check(irq && reg_rdata[6], "R4 pending set", int'(irq), 1);
          check(!rst_req, "R4 no reset in irq mode", int'(rst_req), 0);
        end else begin
          check(rst_req, "R5 reset pulse", int'(rst_req), 1);
          check(!irq && !reg_rdata[6], "R5 no pending", int'(irq), 0);
          @(negedge clk);
          check(!rst_req, "R5 single cycle", int'(rst_req), 0);
        end
        // R7 restart after overflow
        tk(rt, LIM - 1);
        if (md == 1) check(!rst_req, "R7 no early second overflow", int'(rst_req), 0);
        tk(rt, 1);
        if (md == 1) check(rst_req, "R7 second overflow", int'(rst_req), 1);
        else begin
          wr(ctl(1'b0, 1'b0, 1'b1, rt, 1'b0));
          check(irq, "R4 write 0 keeps pending", int'(irq), 1);
          wr(ctl(1'b1, 1'b0, 1'b1, rt, 1'b0));
          check(!irq && !reg_rdata[6], "R4 write 1 clears", int'(irq), 0);
        end
        @(negedge clk);
      end
    end

    // R6 kick mid-count
    wr(ctl(1'b1, 1'b0, 1'b1, 2, 1'b1));
    tk(2, LIM - 1);
    wr(ctl(1'b0, 1'b0, 1'b1, 2, 1'b1));
    @(negedge clk);
    tk(2, LIM - 1);
    check(!irq, "R6 kick restarts count", int'(irq), 0);
    tk(2, 1);
    check(irq, "R6 overflow after full count", int'(irq), 1);

    // R8 hold while disabled
    wr(ctl(1'b1, 1'b0, 1'b1, 3, 1'b1));
    @(negedge clk);
    tk(3, 3);
    wr(ctl(1'b0, 1'b0, 1'b0, 3, 1'b0));
    tk(3, 2 * LIM);
    check(!irq, "R8 ticks ignored when off", int'(irq), 0);
    wr(ctl(1'b0, 1'b0, 1'b1, 3, 1'b0));
    tk(3, LIM - 4);
    check(!irq, "R8 resumes from held value", int'(irq), 0);
    tk(3, 1);
    check(irq, "R8 overflow after resume", int'(irq), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule